// File: doc/BRIEF.md
# Packet Timestamp Latch Bank

This block freezes the running nanosecond time of a port at the moment an upstream classifier flags a precision-time event frame. Receive captures go into a small bank of latch slots, and each accepted receive capture reports which slot now holds its time, so that the descriptor logic can carry the index along with the frame. Transmit captures go into one separate latch. A capture pulse lasts one cycle and marks the cycle whose time value is frozen.

Software reaches the captured times through a small bank of 32-bit registers. It reads a status word that shows which latches are occupied, a control word with one enable for the transmit-capture interrupt, a dropped-capture counter and the low and high halves of every latch. Reading the high half of a latch frees it. A later event can then use that latch. When every receive slot is occupied, further receive captures are dropped and counted.

Top module: `ts_latch_bank`

## Requirements
- R1: After reset no latch is occupied. The status, control and drop registers read as zero, `tx_irq` is low and `rx_cap_ok` is low.
- R2: A receive capture stores the `now_ns` value from its cycle in the lowest-numbered free slot. On the next cycle `rx_cap_ok` is high, `rx_cap_idx` holds that slot number and status bit `i` (bits 3..0 are the receive slots) is set.
- R3: A read of receive slot `i` high (address 9+2i) frees the slot and clears its status bit. A read of its low half (address 8+2i) changes nothing.
- R4: A receive capture with all slots occupied stores nothing and leaves `rx_cap_ok` low. It adds one to the drop counter (address 2), which saturates at its largest value.
- R5: A capture and a high-half read of the same slot in one cycle take the release first. The capture then fills the freed slot, and the read returns the old value.
- R6: A transmit capture stores `now_ns` in the transmit latch (low at address 3, high at address 4) and sets status bit 4. Transmit captures that arrive while the latch is occupied are ignored.
- R7: A read of the transmit high half (address 4) frees the transmit latch and clears status bit 4. A transmit capture in that same cycle fills the latch again.
- R8: `tx_irq` is high exactly while control bit 0 (address 1) is set and the transmit latch is occupied.
- R9: `rd_data` shows the register addressed by `rd_en`/`rd_addr` one cycle after the request, with the value from before that edge.
- R10: Reading the status word does not change it. Reading every high half clears all captures.
- R11: Only control bit 0 is writable. Writes to any other address leave all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_ns | input | 64 | Running nanosecond time |
| rx_cap | input | 1 | Receive capture pulse |
| tx_cap | input | 1 | Transmit capture pulse |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Read data, one cycle after the strobe |
| rx_cap_ok | output | 1 | The receive capture of the previous cycle was stored |
| rx_cap_idx | output | 2 | Slot that took that capture |
| tx_irq | output | 1 | Transmit-capture interrupt, level |

## Verification
The bench keeps the default of four receive slots, so the register addresses and the lowest-free-slot order are tested as they are laid out. It narrows the drop counter to 3 bits. Saturation at 7 then comes within a few captures, and the bench reaches it and tests it. The time input is driven only by the bench, so every latched value can be predicted, including the value kept when a release and a capture meet in one cycle.

// File: rtl/ts_pkg.sv
// Package: register addresses and fixed layout shared by the latch bank.
// Assumes a 4-bit register address and at most four receive slots.
package ts_pkg;
    localparam int ADDR_W     = 4;
    localparam int REG_W      = 32;
    localparam int MAX_RX     = 4;
    localparam int TX_STAT_BIT = 4;

    localparam logic [ADDR_W-1:0] A_STATUS  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd1;
    localparam logic [ADDR_W-1:0] A_DROP    = 4'd2;
    localparam logic [ADDR_W-1:0] A_TX_LO   = 4'd3;
    localparam logic [ADDR_W-1:0] A_TX_HI   = 4'd4;
    localparam int                RX_BASE   = 8;
endpackage

// File: rtl/ts_rx_bank.sv
// Receive slot bank: puts each capture in the lowest free slot, frees slots on
// release, counts dropped captures with saturation. Release takes effect before
// capture within a cycle. Assumes a single-cycle capture pulse.
module ts_rx_bank #(
    parameter int NUM_RX = 4,
    parameter int TIME_W = 64,
    parameter int DROP_W = 16,
    localparam int IDX_W = (NUM_RX > 1) ? $clog2(NUM_RX) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_i,
    input  logic [TIME_W-1:0]        now_i,
    input  logic [NUM_RX-1:0]        rel_i,
    output logic [NUM_RX-1:0]        full_o,
    output logic [NUM_RX*TIME_W-1:0] slots_o,
    output logic                     cap_ok_o,
    output logic [IDX_W-1:0]         cap_idx_o,
    output logic [DROP_W-1:0]        drop_o
);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    logic [NUM_RX-1:0] full_q;
    logic [NUM_RX-1:0] avail;
    logic [NUM_RX-1:0] grant;
    logic [IDX_W-1:0]  pick_idx;
    logic              found;
    logic              take;

    // Slot counts as free if it is empty or released this cycle.
    assign avail = ~full_q | rel_i;
    assign take  = cap_i & found;

    // Lowest-index priority pick among available slots.
    always_comb begin
        grant    = '0;
        pick_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < NUM_RX; i++) begin
            if (avail[i] && !found) begin
                found    = 1'b1;
                pick_idx = IDX_W'(i);
                grant[i] = 1'b1;
            end
        end
    end

    // Occupancy: clear released slots, then set the granted one.
    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= '0;
        else        full_q <= (full_q & ~rel_i) | (take ? grant : '0);
    end

    genvar g;
    generate
        for (g = 0; g < NUM_RX; g++) begin : g_slot
            logic [TIME_W-1:0] stamp_q;
            // Latch the time into this slot when it is granted.
            always_ff @(posedge clk) begin
                if (!rst_n)                stamp_q <= '0;
                else if (take && grant[g]) stamp_q <= now_i;
            end
            assign slots_o[g*TIME_W +: TIME_W] = stamp_q;
        end
    endgenerate

    // Report accepted capture and its slot number to the descriptor path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ok_o  <= 1'b0;
            cap_idx_o <= '0;
        end else begin
            cap_ok_o  <= take;
            cap_idx_o <= take ? pick_idx : cap_idx_o;
        end
    end

    // Saturating counter of captures lost to a full bank.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  drop_o <= '0;
        else if (cap_i && !found && drop_o != DROP_MAX) drop_o <= drop_o + 1'b1;
    end

    assign full_o = full_q;

    p_idx_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ok_o |-> full_o[cap_idx_o]);
    p_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && (!full_q[0] || rel_i[0])) |=> (cap_ok_o && cap_idx_o == '0));
    p_no_cap_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && (&full_q) && rel_i == '0) |=> !cap_ok_o);
    p_drop_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && (&full_q) && rel_i == '0 && drop_o != DROP_MAX)
        |=> drop_o == $past(drop_o) + 1'b1);
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_i && rel_i != '0) |=> (full_o & $past(rel_i)) == '0);
    p_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && (&full_q) && rel_i != '0) |=> (cap_ok_o && (&full_o)));
endmodule

// File: rtl/ts_tx_latch.sv
// Single transmit timestamp latch: holds the first capture until released,
// ignores captures while occupied. Release comes before capture in one cycle.
module ts_tx_latch #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              rel_i,
    input  logic [TIME_W-1:0] now_i,
    output logic              full_o,
    output logic [TIME_W-1:0] time_o
);
    logic take;

    assign take = cap_i && (!full_o || rel_i);

    // Occupancy flag of the transmit latch.
    always_ff @(posedge clk) begin
        if (!rst_n)    full_o <= 1'b0;
        else if (take) full_o <= 1'b1;
        else if (rel_i) full_o <= 1'b0;
    end

    // Captured transmit time.
    always_ff @(posedge clk) begin
        if (!rst_n)    time_o <= '0;
        else if (take) time_o <= now_i;
    end

    p_tx_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !rel_i) |=> (full_o && $stable(time_o)));
    p_tx_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && !cap_i) |=> !full_o);
    p_tx_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && cap_i) |=> (full_o && time_o == $past(now_i)));
endmodule

// File: rtl/ts_csr.sv
// Register file: decodes reads and writes, makes release strobes from
// high-half reads, registers read data with one cycle of latency.
// Assumes NUM_RX <= 4 so slot addresses fit in the 4-bit map.
module ts_csr
    import ts_pkg::*;
#(
    parameter int NUM_RX = 4,
    parameter int TIME_W = 64,
    parameter int DROP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [REG_W-1:0]         wr_data,
    input  logic [NUM_RX-1:0]        rx_full_i,
    input  logic [NUM_RX*TIME_W-1:0] rx_slots_i,
    input  logic                     tx_full_i,
    input  logic [TIME_W-1:0]        tx_time_i,
    input  logic [DROP_W-1:0]        drop_i,
    output logic [REG_W-1:0]         rd_data,
    output logic                     irq_en_o,
    output logic [NUM_RX-1:0]        rx_rel_o,
    output logic                     tx_rel_o
);
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] status;
    logic             wdata_unused;

    assign wdata_unused = &{1'b0, wr_data[REG_W-1:1]};

    // Status word: receive occupancy in low bits, transmit at a fixed bit.
    always_comb begin
        status                 = '0;
        status[NUM_RX-1:0]     = rx_full_i;
        status[TX_STAT_BIT]    = tx_full_i;
    end

    // Release strobes from reads of high halves.
    assign tx_rel_o = rd_en && (rd_addr == A_TX_HI);
    genvar g;
    generate
        for (g = 0; g < NUM_RX; g++) begin : g_rel
            assign rx_rel_o[g] = rd_en && (rd_addr == ADDR_W'(RX_BASE + 2*g + 1));
        end
    endgenerate

    // Control register: only the interrupt enable bit is writable.
    always_ff @(posedge clk) begin
        if (!rst_n)                          irq_en_o <= 1'b0;
        else if (wr_en && wr_addr == A_CTRL) irq_en_o <= wr_data[0];
    end

    // Read multiplexer over the register map.
    always_comb begin
        rd_mux = '0;
        case (rd_addr)
            A_STATUS: rd_mux = status;
            A_CTRL:   rd_mux = {{(REG_W-1){1'b0}}, irq_en_o};
            A_DROP:   rd_mux = REG_W'(drop_i);
            A_TX_LO:  rd_mux = tx_time_i[REG_W-1:0];
            A_TX_HI:  rd_mux = tx_time_i[TIME_W-1:REG_W];
            default:  rd_mux = '0;
        endcase
        for (int i = 0; i < NUM_RX; i++) begin
            if (rd_addr == ADDR_W'(RX_BASE + 2*i))
                rd_mux = rx_slots_i[i*TIME_W +: REG_W];
            if (rd_addr == ADDR_W'(RX_BASE + 2*i + 1))
                rd_mux = rx_slots_i[i*TIME_W + REG_W +: REG_W];
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    p_ctrl_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_CTRL) |=> rd_data == {{(REG_W-1){1'b0}}, $past(irq_en_o)});
    p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_CTRL) |=> $stable(irq_en_o));
endmodule

// File: rtl/ts_latch_bank.sv
// Top: packet timestamp latch bank. Joins the receive slot bank, the transmit
// latch and the register file. Assumes capture pulses come from an upstream
// classifier and that now_ns is in the same clock domain.
module ts_latch_bank #(
    parameter int NUM_RX = 4,
    parameter int DROP_W = 16,
    localparam int TIME_W = 2 * ts_pkg::REG_W,
    localparam int IDX_W  = (NUM_RX > 1) ? $clog2(NUM_RX) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TIME_W-1:0]         now_ns,
    input  logic                      rx_cap,
    input  logic                      tx_cap,
    input  logic                      rd_en,
    input  logic [ts_pkg::ADDR_W-1:0] rd_addr,
    input  logic                      wr_en,
    input  logic [ts_pkg::ADDR_W-1:0] wr_addr,
    input  logic [ts_pkg::REG_W-1:0]  wr_data,
    output logic [ts_pkg::REG_W-1:0]  rd_data,
    output logic                      rx_cap_ok,
    output logic [IDX_W-1:0]          rx_cap_idx,
    output logic                      tx_irq
);
    logic [NUM_RX-1:0]        rx_full;
    logic [NUM_RX*TIME_W-1:0] rx_slots;
    logic [NUM_RX-1:0]        rx_rel;
    logic                     tx_full;
    logic                     tx_rel;
    logic [TIME_W-1:0]        tx_time;
    logic [DROP_W-1:0]        drop_cnt;
    logic                     irq_en;

    ts_rx_bank #(.NUM_RX(NUM_RX), .TIME_W(TIME_W), .DROP_W(DROP_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cap_i(rx_cap), .now_i(now_ns), .rel_i(rx_rel),
        .full_o(rx_full), .slots_o(rx_slots), .cap_ok_o(rx_cap_ok),
        .cap_idx_o(rx_cap_idx), .drop_o(drop_cnt)
    );

    ts_tx_latch #(.TIME_W(TIME_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cap_i(tx_cap), .rel_i(tx_rel), .now_i(now_ns),
        .full_o(tx_full), .time_o(tx_time)
    );

    ts_csr #(.NUM_RX(NUM_RX), .TIME_W(TIME_W), .DROP_W(DROP_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rx_full_i(rx_full), .rx_slots_i(rx_slots), .tx_full_i(tx_full),
        .tx_time_i(tx_time), .drop_i(drop_cnt), .rd_data(rd_data),
        .irq_en_o(irq_en), .rx_rel_o(rx_rel), .tx_rel_o(tx_rel)
    );

    // Level interrupt while enabled and a transmit time waits.
    assign tx_irq = irq_en & tx_full;

    p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_full && !tx_cap) |=> !tx_irq);
    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (!rx_cap_ok && !tx_irq && rd_data == '0));
endmodule

// File: tb/ts_latch_bank_bench.sv
module ts_latch_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] now_ns = '0;
    logic        rx_cap = 1'b0, tx_cap = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [3:0]  rd_addr = '0, wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rx_cap_ok;
    logic [1:0]  rx_cap_idx;
    logic        tx_irq;

    int checks = 0;
    int fails = 0;
    int exp_drop = 0;

    ts_latch_bank #(.NUM_RX(4), .DROP_W(3)) u_ts_latch_bank (
        .clk(clk), .rst_n(rst_n), .now_ns(now_ns), .rx_cap(rx_cap), .tx_cap(tx_cap),
        .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_data(rd_data), .rx_cap_ok(rx_cap_ok),
        .rx_cap_idx(rx_cap_idx), .tx_irq(tx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        step(); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(); wr_en = 1'b0;
    endtask

    task automatic rx_capture(input logic [63:0] t);
        @(negedge clk); rx_cap = 1'b1; now_ns = t;
        step(); rx_cap = 1'b0;
    endtask

    task automatic tx_capture(input logic [63:0] t);
        @(negedge clk); tx_cap = 1'b1; now_ns = t;
        step(); tx_cap = 1'b0;
    endtask

    task automatic test_reset();
        logic [31:0] d;
        chk("R1 cap_ok", rx_cap_ok, 0);
        chk("R1 irq", tx_irq, 0);
        rd(4'd0, d); chk("R1 status", d, 0);
        rd(4'd1, d); chk("R1 ctrl", d, 0);
        rd(4'd2, d); chk("R1 drop", d, 0);
    endtask

    task automatic test_fill_lowest();
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
            rx_capture(64'h1111_0000_0000_0010 + 64'(k));
            chk("R2 ok", rx_cap_ok, 1);
            chk("R2 idx", rx_cap_idx, 64'(k));
        end
        rd(4'd0, d); chk("R2 status full", d, 32'hF);
        rd(4'd12, d); chk("R9 slot2 low", d, 32'h12);
        rd(4'd0, d); chk("R3 low read keeps", d, 32'hF);
        rd(4'd13, d); chk("R9 slot2 high", d, 32'h1111_0000);
        rd(4'd0, d); chk("R3 high read frees", d, 32'hB);
        rx_capture(64'hAAAA_0000_0000_00A0);
        chk("R2 refill idx", rx_cap_idx, 2);
        rd(4'd15, d); rd(4'd11, d);
        rd(4'd0, d); chk("R3 two freed", d, 32'h5);
        rx_capture(64'h2222_0000_0000_0021);
        chk("R2 lowest idx1", rx_cap_idx, 1);
        rx_capture(64'h3333_0000_0000_0033);
        chk("R2 lowest idx3", rx_cap_idx, 3);
        rd(4'd10, d); chk("R2 slot1 value", d, 32'h21);
        rd(4'd0, d); chk("R2 status refull", d, 32'hF);
    endtask

    task automatic test_drop();
        logic [31:0] d;
        for (int k = 0; k < 9; k++) begin
            rx_capture(64'hDEAD_0000_0000_0000 + 64'(k));
            chk("R4 not stored", rx_cap_ok, 0);
            if (exp_drop < 7) exp_drop++;
        end
        rd(4'd2, d); chk("R4 drop saturated", d, 32'(exp_drop));
        rd(4'd0, d); chk("R4 status unchanged", d, 32'hF);
        rd(4'd8, d); chk("R4 slot0 kept", d, 32'h10);
    endtask

    task automatic test_same_cycle();
        logic [31:0] d;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'd9; rx_cap = 1'b1; now_ns = 64'hBEEF_0000_0000_0BEE;
        step(); rd_en = 1'b0; rx_cap = 1'b0;
        chk("R5 cap ok", rx_cap_ok, 1);
        chk("R5 idx0", rx_cap_idx, 0);
        chk("R5 old read", rd_data, 32'h1111_0000);
        rd(4'd0, d); chk("R5 status full", d, 32'hF);
        rd(4'd2, d); chk("R5 no drop", d, 32'(exp_drop));
        rd(4'd8, d); chk("R5 new low", d, 32'h0BEE);
    endtask

    task automatic test_clear_all();
        logic [31:0] d;
        rd(4'd0, d); chk("R10 status", d, 32'hF);
        rd(4'd0, d); chk("R10 status nondestructive", d, 32'hF);
        rd(4'd9, d); rd(4'd11, d); rd(4'd13, d); rd(4'd15, d);
        rd(4'd0, d); chk("R10 all cleared", d, 0);
    endtask

    task automatic test_tx();
        logic [31:0] d;
        tx_capture(64'h0123_4567_89AB_CDEF);
        rd(4'd0, d); chk("R6 status tx", d, 32'h10);
        chk("R8 irq off while disabled", tx_irq, 0);
        tx_capture(64'hFFFF_FFFF_FFFF_FFFF);
        rd(4'd3, d); chk("R6 ignored while full", d, 32'h89AB_CDEF);
        wr(4'd1, 32'h1);
        chk("R8 irq on", tx_irq, 1);
        rd(4'd1, d); chk("R11 ctrl bit", d, 32'h1);
        rd(4'd4, d); chk("R6 tx high", d, 32'h0123_4567);
        chk("R7 irq drops on release", tx_irq, 0);
        rd(4'd0, d); chk("R7 status cleared", d, 0);
        tx_capture(64'h0000_0005_0000_0777);
        chk("R8 irq again", tx_irq, 1);
        rd(4'd3, d); chk("R6 new tx low", d, 32'h777);
        wr(4'd1, 32'h0);
        chk("R8 irq off by ctrl", tx_irq, 0);
    endtask

    task automatic test_ignored_writes();
        logic [31:0] d;
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd3, 32'h1234_5678);
        rd(4'd0, d); chk("R11 status unchanged", d, 32'h10);
        rd(4'd2, d); chk("R11 drop unchanged", d, 32'(exp_drop));
        rd(4'd3, d); chk("R11 tx low unchanged", d, 32'h777);
        rd(4'd1, d); chk("R11 ctrl unchanged", d, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        step();
        test_reset();
        test_fill_lowest();
        test_drop();
        test_same_cycle();
        test_clear_all();
        test_tx();
        test_ignored_writes();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule